// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes a slow three-wire programming port made of a serial clock, a serial data line and a load strobe, and turns it into parallel configuration words for a frequency synthesizer. All three wires are asynchronous to the system clock. Each is brought into the system clock domain through a multi-stage synchronizer, and the serial clock and load strobe are edge-detected there. Each rising edge of the serial clock shifts one data bit into a 20-bit shift register, most significant bit first.

On a rising edge of the load strobe, the two bits shifted in last (word bits 1 and 0) act as a target address. Bit 0 set picks the 18-bit function word, whatever bit 1 holds. With bit 0 clear, bit 1 picks between the reference divider (bit 1 set) and the feedback divider (bit 1 clear). The feedback divider holds a 6-bit swallow count and a 7-bit main count. The other bits of the word go into the chosen register, and that register raises a one-cycle write strobe. The other registers hold their values.

Top module: `serprog_loader`

## Requirements
- R1: While `rst` is high, and after it falls, all register outputs read zero and no write strobe is high until the first load.
- R2: A data bit is captured only on a rising edge of `ser_clk_i`, and the first bit sent ends up at word bit 19 (most significant bit first). Falling edges of the serial clock shift nothing.
- R3: A load with word bits [1:0] = 00 sets `div_a_o` from word bits [7:2] and `div_b_o` from word bits [14:8]. Word bits [19:15] have no effect.
- R4: A load with word bits [1:0] = 10 sets `ref_div_o` from word bits [6:2]. Word bits [19:7] have no effect.
- R5: A load with word bit 0 = 1 sets `func_o` from word bits [19:2] (func bit 0 = word bit 2), for both values of word bit 1.
- R6: A load leaves the two registers it does not address unchanged.
- R7: Each load raises exactly one write strobe, the one for the addressed register, for exactly one system clock cycle.
- R8: Shifting with no rising edge on `ser_le_i` changes no register. A later load-strobe edge alone transfers the word that was shifted in before it.
- R9: When more than 20 bits are shifted before a load, only the last 20 bits sent are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock; data is captured on its rising edge |
| ser_dat_i | input | 1 | Asynchronous serial data, MSB first |
| ser_le_i | input | 1 | Asynchronous load strobe; the transfer happens on its rising edge |
| div_a_o | output | 6 | Feedback divider swallow count |
| div_b_o | output | 7 | Feedback divider main count |
| ref_div_o | output | 5 | Reference divider count |
| func_o | output | 18 | Function / mode word |
| div_wr_o | output | 1 | One-cycle strobe on a feedback divider update |
| ref_wr_o | output | 1 | One-cycle strobe on a reference divider update |
| func_wr_o | output | 1 | One-cycle strobe on a function word update |

## Verification
If the shift register drops or duplicates a bit, or shifts on the wrong edge, the fields show up at the ports shifted or wrongly placed. This is visible a few system cycles after the next load strobe, and each field is checked against a distinct bit pattern. If the address decode is wrong, data goes to the wrong register or a register that should hold changes, and the wrong strobe fires within the same cycle. The strobe counters show an extra, missing or stretched pulse at once. A load path that fires without a load-strobe edge shows up as an output change in the no-load test.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

    localparam int WORD_W = 20;
    localparam int ADDR_W = 2;
    localparam int A_W    = 6;
    localparam int B_W    = 7;
    localparam int R_W    = 5;
    localparam int F_W    = 18;

    localparam int A_LSB  = ADDR_W;
    localparam int B_LSB  = A_LSB + A_W;
    localparam int R_LSB  = ADDR_W;
    localparam int F_LSB  = ADDR_W;

    typedef enum logic [1:0] {
        TGT_DIV  = 2'd0,
        TGT_REF  = 2'd1,
        TGT_FUNC = 2'd2
    } tgt_e;

    typedef struct packed {
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } div_t;

    // Bit 0 alone selects the function word; bit 1 splits the dividers.
    function automatic tgt_e decode_addr(input logic [ADDR_W-1:0] ctl);
        if (ctl[0])      return TGT_FUNC;
        else if (ctl[1]) return TGT_REF;
        else             return TGT_DIV;
    endfunction

endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= async_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/serprog_shifter.sv
module serprog_shifter
    import serprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], bit_i};
    end

    assign word_o = sr_q;
endmodule

// File: rtl/serprog_latches.sv
module serprog_latches
    import serprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_i,
    output div_t              div_o,
    output logic [R_W-1:0]    ref_o,
    output logic [F_W-1:0]    func_o,
    output logic              div_wr_o,
    output logic              ref_wr_o,
    output logic              func_wr_o
);
    tgt_e tgt;
    div_t div_q;
    logic [R_W-1:0] ref_q;
    logic [F_W-1:0] func_q;
    logic div_wr_q, ref_wr_q, func_wr_q;

    assign tgt = decode_addr(word_i[ADDR_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            ref_q     <= '0;
            func_q    <= '0;
            div_wr_q  <= 1'b0;
            ref_wr_q  <= 1'b0;
            func_wr_q <= 1'b0;
        end else begin
            div_wr_q  <= 1'b0;
            ref_wr_q  <= 1'b0;
            func_wr_q <= 1'b0;
            if (load) begin
                unique case (tgt)
                    TGT_DIV: begin
                        div_q.a  <= word_i[A_LSB +: A_W];
                        div_q.b  <= word_i[B_LSB +: B_W];
                        div_wr_q <= 1'b1;
                    end
                    TGT_REF: begin
                        ref_q    <= word_i[R_LSB +: R_W];
                        ref_wr_q <= 1'b1;
                    end
                    default: begin
                        func_q    <= word_i[F_LSB +: F_W];
                        func_wr_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign div_o     = div_q;
    assign ref_o     = ref_q;
    assign func_o    = func_q;
    assign div_wr_o  = div_wr_q;
    assign ref_wr_o  = ref_wr_q;
    assign func_wr_o = func_wr_q;
endmodule

// File: rtl/serprog_loader.sv
module serprog_loader
    import serprog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk_i,
    input  logic           ser_dat_i,
    input  logic           ser_le_i,
    output logic [A_W-1:0] div_a_o,
    output logic [B_W-1:0] div_b_o,
    output logic [R_W-1:0] ref_div_o,
    output logic [F_W-1:0] func_o,
    output logic           div_wr_o,
    output logic           ref_wr_o,
    output logic           func_wr_o
);
    logic [2:0] pins_s;
    logic sclk_s, sdat_s, sle_s;
    logic sclk_d, sle_d;
    logic shift_en, load;
    logic [WORD_W-1:0] word;
    div_t div;

    serprog_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_le_i, ser_clk_i, ser_dat_i}),
        .sync_o  (pins_s)
    );

    assign {sle_s, sclk_s, sdat_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            sle_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sle_d  <= sle_s;
        end
    end

    assign shift_en = sclk_s & ~sclk_d;
    assign load     = sle_s & ~sle_d;

    serprog_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_i    (sdat_s),
        .word_o   (word)
    );

    serprog_latches u_lat (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .word_i    (word),
        .div_o     (div),
        .ref_o     (ref_div_o),
        .func_o    (func_o),
        .div_wr_o  (div_wr_o),
        .ref_wr_o  (ref_wr_o),
        .func_wr_o (func_wr_o)
    );

    assign div_a_o = div.a;
    assign div_b_o = div.b;
endmodule

// File: rtl/serprog_loader_chk.sv
module serprog_loader_chk
    import serprog_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [A_W-1:0] div_a_o,
    input logic [B_W-1:0] div_b_o,
    input logic [R_W-1:0] ref_div_o,
    input logic [F_W-1:0] func_o,
    input logic           div_wr_o,
    input logic           ref_wr_o,
    input logic           func_wr_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (div_a_o == '0 && div_b_o == '0 && ref_div_o == '0 &&
                 func_o == '0 && !div_wr_o && !ref_wr_o && !func_wr_o));

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({div_wr_o, ref_wr_o, func_wr_o}));

    // R7
    div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        div_wr_o |=> !div_wr_o);

    // R7
    ref_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ref_wr_o |=> !ref_wr_o);

    // R7
    func_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        func_wr_o |=> !func_wr_o);

    // R6
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !div_wr_o |-> ($stable(div_a_o) && $stable(div_b_o)));

    // R6
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_wr_o |-> $stable(ref_div_o));

    // R6
    func_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !func_wr_o |-> $stable(func_o));
endmodule

bind serprog_loader serprog_loader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_a_o   (div_a_o),
    .div_b_o   (div_b_o),
    .ref_div_o (ref_div_o),
    .func_o    (func_o),
    .div_wr_o  (div_wr_o),
    .ref_wr_o  (ref_wr_o),
    .func_wr_o (func_wr_o)
);

// File: tb/tb_serprog_loader.sv
module tb_serprog_loader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [5:0]  div_a;
    logic [6:0]  div_b;
    logic [4:0]  ref_div;
    logic [17:0] func;
    logic div_wr, ref_wr, func_wr;

    int n_checks = 0, n_fail = 0;
    int div_cnt = 0, ref_cnt = 0, func_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serprog_loader dut (
        .clk       (clk),
        .rst       (rst),
        .ser_clk_i (ser_clk),
        .ser_dat_i (ser_dat),
        .ser_le_i  (ser_le),
        .div_a_o   (div_a),
        .div_b_o   (div_b),
        .ref_div_o (ref_div),
        .func_o    (func),
        .div_wr_o  (div_wr),
        .ref_wr_o  (ref_wr),
        .func_wr_o (func_wr)
    );

    // Strobe cycle counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (div_wr)  div_cnt++;
        if (ref_wr)  ref_cnt++;
        if (func_wr) func_cnt++;
    end

    task automatic check(input string req, input string what,
                         input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = w[i];
            idle(4);
            ser_clk = 1'b1;
            idle(4);
            ser_clk = 1'b0;
            idle(4);
        end
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        idle(4);
        ser_le = 1'b0;
        idle(6);
    endtask

    task automatic check_strobes(input string req, input int dd, input int dr,
                                 input int df, input int d0, input int r0,
                                 input int f0);
        check(req, "div strobe cycles",  div_cnt  - d0, dd);
        check(req, "ref strobe cycles",  ref_cnt  - r0, dr);
        check(req, "func strobe cycles", func_cnt - f0, df);
    endtask

    task automatic t_reset();
        check("R1", "div_a", int'(div_a), 0);
        check("R1", "div_b", int'(div_b), 0);
        check("R1", "ref", int'(ref_div), 0);
        check("R1", "func", int'(func), 0);
        check("R1", "strobes", div_cnt + ref_cnt + func_cnt, 0);
    endtask

    task automatic t_div();
        int d0 = div_cnt, r0 = ref_cnt, f0 = func_cnt;
        shift_bits({12'h0, 5'h1F, 7'h5A, 6'h2D, 2'b00}, 20);
        pulse_le();
        check("R3", "div_a", int'(div_a), 'h2D);
        check("R3", "div_b", int'(div_b), 'h5A);
        check("R6", "ref held", int'(ref_div), 0);
        check("R6", "func held", int'(func), 0);
        check_strobes("R7", 1, 0, 0, d0, r0, f0);
    endtask

    task automatic t_ref();
        int d0 = div_cnt, r0 = ref_cnt, f0 = func_cnt;
        shift_bits({12'h0, 13'h1FFF, 5'h13, 2'b10}, 20);
        pulse_le();
        check("R4", "ref", int'(ref_div), 'h13);
        check("R6", "div_a held", int'(div_a), 'h2D);
        check("R6", "div_b held", int'(div_b), 'h5A);
        check("R6", "func held", int'(func), 0);
        check_strobes("R7", 0, 1, 0, d0, r0, f0);
    endtask

    task automatic t_func();
        int d0 = div_cnt, r0 = ref_cnt, f0 = func_cnt;
        shift_bits({12'h0, 18'h2A5C3, 2'b01}, 20);
        pulse_le();
        check("R5", "func addr 01", int'(func), 'h2A5C3);
        check("R2", "msb first func", int'(func[17]), 1);
        check_strobes("R7", 0, 0, 1, d0, r0, f0);
        shift_bits({12'h0, 18'h15A3C, 2'b11}, 20);
        pulse_le();
        check("R5", "func addr 11", int'(func), 'h15A3C);
        check("R6", "ref held", int'(ref_div), 'h13);
        check("R6", "div_a held", int'(div_a), 'h2D);
    endtask

    task automatic t_noload();
        int d0 = div_cnt, r0 = ref_cnt, f0 = func_cnt;
        shift_bits({12'h0, 5'h0, 7'h11, 6'h07, 2'b00}, 20);
        idle(10);
        check("R8", "div_a no load", int'(div_a), 'h2D);
        check("R8", "div_b no load", int'(div_b), 'h5A);
        check_strobes("R8", 0, 0, 0, d0, r0, f0);
        pulse_le();
        check("R8", "div_a late load", int'(div_a), 'h07);
        check("R8", "div_b late load", int'(div_b), 'h11);
    endtask

    task automatic t_overflow();
        int d0 = div_cnt, r0 = ref_cnt, f0 = func_cnt;
        shift_bits(32'hA, 4);
        shift_bits({12'h0, 18'h00F0F, 2'b01}, 20);
        pulse_le();
        check("R9", "func last 20 bits", int'(func), 'h00F0F);
        check_strobes("R9", 0, 0, 1, d0, r0, f0);
    endtask

    initial begin
        idle(5);
        t_reset();
        rst = 1'b0;
        idle(5);
        t_reset();
        t_div();
        t_ref();
        t_func();
        t_noload();
        t_overflow();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule